// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides one 32-bit integer by another over several clock cycles, using the restoring method. A single-cycle `start` pulse captures the two operands and a mode select. The select treats the operands either as unsigned numbers or as two's-complement numbers. In signed mode the block first turns both operands into magnitudes. An unsigned core then does the division. Its core holds the divisor in the upper half of a double-width register, and the remainder in a double-width register that is first loaded with the dividend magnitude.

The core runs 33 passes, one pass per clock. Each pass does the following:
- It subtracts the shifted divisor from the working remainder.
- On a negative difference it keeps the old remainder, which is the same as adding the divisor back, and shifts a 0 into the quotient.
- Otherwise it keeps the difference and shifts in a 1.
- It then moves the divisor one place to the right.

After the last pass the block negates the quotient and the remainder as the sign rules demand. It places the quotient on `lo` and the remainder on `hi`, and raises `done` for one cycle. The results stay on the outputs until the next division finishes. A zero divisor is reported on `div_by_zero`. The block does not flag a quotient that is too large to fit.

Top module: `rdiv_top`

## Requirements
- R1: During reset and after it, before any division, `done`, `lo`, `hi` and `div_by_zero` are all 0.
- R2: With `is_signed`=0 and a nonzero divisor, `lo` is the floor of dividend/divisor and `hi` is dividend mod divisor, with both operands read as unsigned. So dividend = divisor×lo + hi and hi < divisor.
- R3: With `is_signed`=1, `lo` is the two's-complement quotient truncated toward zero. It is negative exactly when the operand signs differ and the magnitude quotient is nonzero.
- R4: With `is_signed`=1, `hi` is zero or carries the sign of the dividend, and its magnitude is less than the divisor's. dividend = divisor×lo + hi holds modulo 2^32 for all four sign combinations.
- R5: A `start` that is seen while the block is idle is accepted. `done` is then high for exactly one cycle, which is the 34th cycle after the accepting clock edge.
- R6: While a division is in progress, `start` and any change of `dividend`, `divisor` or `is_signed` have no effect on the result being computed.
- R7: `div_by_zero` is updated together with `done`. It is 1 when the captured divisor was 0 and 0 otherwise. `lo` and `hi` are unspecified in that case.
- R8: Between two `done` pulses, `lo`, `hi` and `div_by_zero` hold their values.
- R9: The signed case -2^31 / -1 gives `lo`=0x80000000 and `hi`=0. `div_by_zero` stays 0 and no overflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Starts a division when the block is idle |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| dividend | input | 32 | Dividend, captured on accept |
| divisor | input | 32 | Divisor, captured on accept |
| done | output | 1 | One-cycle pulse when the results are presented |
| lo | output | 32 | Quotient |
| hi | output | 32 | Remainder |
| div_by_zero | output | 1 | Captured divisor was zero |

## Verification
The bound checker keeps its own copy of the captured operands. With that copy it checks every cycle that `done` is a single-cycle pulse at the fixed latency, and that the results and the zero-divisor flag stay unchanged between pulses. On every `done` it also checks the division identity, the unsigned bound on the remainder and the remainder-sign rule. Some behaviour only the bench scenarios can show:
- exact quotient values, including rounding toward zero for each sign pairing;
- the -2^31 / -1 wrap;
- that operand changes and repeated `start` during a run are ignored;
- the reset values.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_rst_sync.sv
module rdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rdiv_operand_prep.sv
module rdiv_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvs_mag,
  output logic         q_neg,
  output logic         r_neg,
  output logic         dvs_zero
);
  logic dvd_sign;
  logic dvs_sign;

  always_comb begin
    dvd_sign = is_signed & dividend[W-1];
    dvs_sign = is_signed & divisor[W-1];
    dvd_mag  = dvd_sign ? (~dividend + 1'b1) : dividend;
    dvs_mag  = dvs_sign ? (~divisor + 1'b1) : divisor;
    q_neg    = dvd_sign ^ dvs_sign;
    r_neg    = dvd_sign;
    dvs_zero = (divisor == '0);
  end
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] rem_in,
  input  logic [2*W-1:0] dvs_in,
  input  logic [W-1:0]   quo_in,
  output logic [2*W-1:0] rem_out,
  output logic [2*W-1:0] dvs_out,
  output logic [W-1:0]   quo_out
);
  localparam int W2 = 2 * W;

  logic [W2:0] diff;
  logic        went_neg;

  always_comb begin
    diff     = {1'b0, rem_in} - {1'b0, dvs_in};
    went_neg = diff[W2];
    // A negative trial restores the old remainder; otherwise the difference is kept.
    rem_out  = went_neg ? rem_in : diff[W2-1:0];
    quo_out  = {quo_in[W-2:0], ~went_neg};
    dvs_out  = {1'b0, dvs_in[W2-1:1]};
  end
endmodule

// File: rtl/rdiv_sign_fix.sv
module rdiv_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         q_neg,
  input  logic         r_neg,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out
);
  always_comb begin
    quo_out = q_neg ? (~quo_mag + 1'b1) : quo_mag;
    rem_out = r_neg ? (~rem_mag + 1'b1) : rem_mag;
  end
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         div_by_zero
);
  import rdiv_pkg::*;

  localparam int W2   = 2 * W;
  localparam int ITER = W + 1;
  localparam int CW   = $clog2(ITER + 1);

  logic rst_sync_n;

  rdiv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic load_en, step_en, fin_en;

  logic [W2-1:0] rem_q, rem_d, rem_step;
  logic [W2-1:0] dvs_q, dvs_d, dvs_step;
  logic [W-1:0]  quo_q, quo_d, quo_step;
  logic          qneg_q, rneg_q, zero_q;

  logic [W-1:0] dvd_mag, dvs_mag;
  logic         q_neg_in, r_neg_in, dvs_zero_in;
  logic [W-1:0] lo_fix, hi_fix;

  logic [W-1:0] lo_q, hi_q;
  logic         dbz_q, done_q;

  rdiv_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rdiv_operand_prep #(.W(W)) u_prep (
    .dividend  (dividend),
    .divisor   (divisor),
    .is_signed (is_signed),
    .dvd_mag   (dvd_mag),
    .dvs_mag   (dvs_mag),
    .q_neg     (q_neg_in),
    .r_neg     (r_neg_in),
    .dvs_zero  (dvs_zero_in)
  );

  rdiv_step #(.W(W)) u_step (
    .rem_in  (rem_q),
    .dvs_in  (dvs_q),
    .quo_in  (quo_q),
    .rem_out (rem_step),
    .dvs_out (dvs_step),
    .quo_out (quo_step)
  );

  rdiv_sign_fix #(.W(W)) u_fix (
    .quo_mag (quo_q),
    .rem_mag (rem_q[W-1:0]),
    .q_neg   (qneg_q),
    .r_neg   (rneg_q),
    .quo_out (lo_fix),
    .rem_out (hi_fix)
  );

  // Control: next state and enables
  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    step_en = 1'b0;
    fin_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_en = 1'b1;
        if (cnt_q == CW'(ITER - 1)) state_d = ST_FIN;
      end
      ST_FIN: begin
        fin_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (load_en)      cnt_d = '0;
    else if (step_en) cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  // Datapath next values
  always_comb begin
    rem_d = rem_q;
    dvs_d = dvs_q;
    quo_d = quo_q;
    if (load_en) begin
      rem_d = {{W{1'b0}}, dvd_mag};
      dvs_d = {dvs_mag, {W{1'b0}}};
      quo_d = '0;
    end else if (step_en) begin
      rem_d = rem_step;
      dvs_d = dvs_step;
      quo_d = quo_step;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= fin_en;
    end
  end

  // Working registers, no reset
  always_ff @(posedge clk) begin
    if (load_en || step_en) begin
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      quo_q <= quo_d;
    end
    if (load_en) begin
      qneg_q <= q_neg_in;
      rneg_q <= r_neg_in;
      zero_q <= dvs_zero_in;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      dbz_q <= 1'b0;
    end else if (fin_en) begin
      lo_q  <= lo_fix;
      hi_q  <= hi_fix;
      dbz_q <= zero_q;
    end
  end

  assign done        = done_q;
  assign lo          = lo_q;
  assign hi          = hi_q;
  assign div_by_zero = dbz_q;
endmodule

// File: rtl/rdiv_checks.sv
module rdiv_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         is_signed,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         done,
  input logic [W-1:0] lo,
  input logic [W-1:0] hi,
  input logic         div_by_zero
);
  localparam int LAT = W + 2;
  localparam int KW  = $clog2(LAT + 1);

  logic          ck_busy;
  logic [KW-1:0] ck_cnt;
  logic [W-1:0]  ck_dvd, ck_dvs;
  logic          ck_sgn;
  logic          accept;

  logic [2*W-1:0] uns_sum;
  logic [W-1:0]   mod_sum;

  assign accept = start && (!ck_busy || done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_busy <= 1'b0;
      ck_cnt  <= '0;
      ck_dvd  <= '0;
      ck_dvs  <= '0;
      ck_sgn  <= 1'b0;
    end else if (accept) begin
      ck_busy <= 1'b1;
      ck_cnt  <= '0;
      ck_dvd  <= dividend;
      ck_dvs  <= divisor;
      ck_sgn  <= is_signed;
    end else if (done) begin
      ck_busy <= 1'b0;
    end else if (ck_busy) begin
      ck_cnt  <= ck_cnt + 1'b1;
    end
  end

  always_comb begin
    uns_sum = {{W{1'b0}}, lo} * {{W{1'b0}}, ck_dvs} + {{W{1'b0}}, hi};
    mod_sum = uns_sum[W-1:0];
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ck_busy && ck_cnt == KW'(LAT))); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(lo) && $stable(hi))); // R8
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(div_by_zero)); // R7
  AST_FLAG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_by_zero == (ck_dvs == '0))); // R7
  AST_UNS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ck_sgn && ck_dvs != '0) |-> (uns_sum == {{W{1'b0}}, ck_dvd} && hi < ck_dvs)); // R2
  AST_SGN_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_sgn && ck_dvs != '0) |-> (mod_sum == ck_dvd)); // R4
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_sgn && ck_dvs != '0 && hi != '0) |-> (hi[W-1] == ck_dvd[W-1])); // R4
endmodule

bind rdiv_top rdiv_checks #(.W(W)) u_rdiv_checks (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start       (start),
  .is_signed   (is_signed),
  .dividend    (dividend),
  .divisor     (divisor),
  .done        (done),
  .lo          (lo),
  .hi          (hi),
  .div_by_zero (div_by_zero)
);

// File: tb/rdiv_top_bench.sv
module rdiv_top_bench;
  localparam int W   = 32;
  localparam int LAT = W + 2;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         is_signed;
  logic [W-1:0] dividend;
  logic [W-1:0] divisor;
  logic         done;
  logic [W-1:0] lo;
  logic [W-1:0] hi;
  logic         div_by_zero;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit model_on = 0;
  bit finished = 0;

  rdiv_top #(.W(W)) u_rdiv_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .is_signed   (is_signed),
    .dividend    (dividend),
    .divisor     (divisor),
    .done        (done),
    .lo          (lo),
    .hi          (hi),
    .div_by_zero (div_by_zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // Reference model: divide with integer arithmetic, count latency in cycles
  int           m_cnt;
  bit           m_done;
  bit           m_dbz;
  bit           m_unspec;
  bit           m_sgn_op;
  logic [W-1:0] m_a, m_b;
  logic [W-1:0] hold_lo, hold_hi;

  function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input bit sgn, output logic [W-1:0] q,
                                  output logic [W-1:0] r);
    longint sa, sb, sq, sr;
    if (!sgn) begin
      q = a / b;
      r = a % b;
    end else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      sq = sa / sb;
      sr = sa % sb;
      q  = sq[W-1:0];
      r  = sr[W-1:0];
    end
  endfunction

  always @(posedge clk) begin
    if (!model_on) begin
      m_cnt = 0; m_done = 0; m_dbz = 0; m_unspec = 0;
      hold_lo = '0; hold_hi = '0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1;
          if (m_b == '0) begin
            m_dbz = 1; m_unspec = 1;
          end else begin
            m_dbz = 0; m_unspec = 0;
            ref_div(m_a, m_b, m_sgn_op, hold_lo, hold_hi);
          end
        end
      end else if (start) begin
        m_a = dividend; m_b = divisor; m_sgn_op = is_signed;
        m_cnt = LAT;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      chk(done === m_done, "R5", "done", {31'b0, done}, {31'b0, m_done});
      if (m_done) begin
        chk(div_by_zero === m_dbz, "R7", "div_by_zero", {31'b0, div_by_zero}, {31'b0, m_dbz});
        if (m_unspec) begin
          hold_lo = lo; hold_hi = hi;
        end else begin
          chk(lo === hold_lo, m_sgn_op ? "R3" : "R2", "quotient", lo, hold_lo);
          chk(hi === hold_hi, m_sgn_op ? "R4" : "R2", "remainder", hi, hold_hi);
        end
      end else begin
        chk(lo === hold_lo && hi === hold_hi, "R8", "held lo", lo, hold_lo);
        chk(div_by_zero === m_dbz, "R8", "held flag", {31'b0, div_by_zero}, {31'b0, m_dbz});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk(1'b0, "R5", "done never seen", '0, 1);
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; is_signed = sgn;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  task automatic run_exp(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn,
                         input logic [W-1:0] eq, input logic [W-1:0] er, input string tag);
    run_div(a, b, sgn);
    chk(lo === eq, tag, "quotient", lo, eq);
    chk(hi === er, tag, "remainder", hi, er);
    chk(div_by_zero === 1'b0, tag, "flag", {31'b0, div_by_zero}, '0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(done === 1'b0 && div_by_zero === 1'b0, "R1", "done/flag in reset", {31'b0, done}, '0);
    chk(lo === '0 && hi === '0, "R1", "results in reset", lo | hi, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done === 1'b0 && lo === '0 && hi === '0 && div_by_zero === 1'b0, "R1",
        "after release", lo | hi, '0);
    model_on = 1;

    // R2: unsigned
    run_exp(32'd73, 32'd5, 1'b0, 32'd14, 32'd3, "R2");
    run_exp(32'd4, 32'd9, 1'b0, 32'd0, 32'd4, "R2");
    run_exp(32'hFFFF_FFFF, 32'd1, 1'b0, 32'hFFFF_FFFF, 32'd0, "R2");
    run_exp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'd1, 32'd0, "R2");
    run_exp(32'hF000_0000, 32'd7, 1'b0, 32'h2249_2492, 32'd2, "R2");

    // R3 / R4: four sign combinations of 7 and 2
    run_exp(32'd7, 32'd2, 1'b1, 32'd3, 32'd1, "R3");
    run_exp(-32'sd7, 32'd2, 1'b1, -32'sd3, -32'sd1, "R4");
    run_exp(32'd7, -32'sd2, 1'b1, -32'sd3, 32'd1, "R3");
    run_exp(-32'sd7, -32'sd2, 1'b1, 32'd3, -32'sd1, "R4");
    run_exp(-32'sd1, 32'd5, 1'b1, 32'd0, -32'sd1, "R4");
    // Same bits, unsigned reading
    run_exp(-32'sd7, 32'd2, 1'b0, 32'h7FFF_FFFC, 32'd1, "R2");

    // R9: overflow wraps and is not flagged
    run_exp(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 32'h8000_0000, 32'd0, "R9");

    // R7: zero divisor in both modes, then a normal divide clears the flag
    run_div(32'd123, 32'd0, 1'b0);
    chk(div_by_zero === 1'b1, "R7", "flag unsigned", {31'b0, div_by_zero}, 1);
    run_div(-32'sd9, 32'd0, 1'b1);
    chk(div_by_zero === 1'b1, "R7", "flag signed", {31'b0, div_by_zero}, 1);
    run_exp(32'd10, 32'd3, 1'b0, 32'd3, 32'd1, "R7");

    // R6: operands and start wiggle during a run
    @(negedge clk);
    start = 1'b1; dividend = 32'd1000; divisor = 32'd7; is_signed = 1'b0;
    @(negedge clk);
    dividend = 32'hDEAD_BEEF; divisor = 32'd0; is_signed = 1'b1;
    repeat (10) @(negedge clk);
    dividend = 32'd5; divisor = 32'd5;
    repeat (5) @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(lo === 32'd142 && hi === 32'd6, "R6", "result after wiggle", lo, 32'd142);

    // R2 / R3 / R4 pseudo-random mix
    for (int k = 0; k < 60; k++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = (k % 3 == 0) ? ($urandom & 32'h0000_FFFF) : $urandom;
      if (b == '0) b = 32'd3;
      run_div(a, b, k[0]);
      // values are compared by the per-cycle model
    end

    // Back-to-back: start held through done gets accepted right after
    @(negedge clk);
    start = 1'b1; dividend = 32'd50; divisor = 32'd6; is_signed = 1'b0;
    wait_done();
    dividend = 32'd51; divisor = 32'd6;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(lo === 32'd8 && hi === 32'd3, "R5", "second back-to-back", lo, 32'd8);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule